// File: doc/BRIEF.md
# Processor exception entry controller

This block carries out the hardware half of taking an exception in a small RISC core. It owns the status register, the saved-PC and saved-SR shadow registers, the exception and interrupt event-code registers and the vector base register. The pipeline presents requests on four lines: a reset request, a synchronous exception with a TLB-miss flag, a return-from-exception, and an interrupt. The pipeline also presents the current PC and the event codes. When a request is taken, the block updates its registers at the clock edge and raises a one-cycle redirect to the fetch unit, carrying the target address.

On entry, the PC and the pre-entry SR are copied into the shadow registers. Three SR control bits are then forced to 1: block (bit 28), register bank (bit 29) and privileged mode (bit 30). The 12-bit code is written into the event register that belongs to the class of the request. Reset redirects to a fixed address. The other classes add a fixed offset to the vector base register. A return restores SR from the saved SR and redirects to the saved PC. While the block bit is set, only reset and return are accepted.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On a taken exception or interrupt, the saved-PC register gets `pc_in` and the saved-SR register gets the SR value from before the edge.
- R2: On a taken exception or interrupt, SR bits 28, 29 and 30 become 1 and all other SR bits keep their value.
- R3: A taken exception writes `exc_code` into the exception event register, and a taken interrupt writes `irq_code` into the interrupt event register. The other event register is left unchanged. A reset request clears the exception event register to 0.
- R4: A reset request redirects to 0xA0000000 whatever VBR holds. It sets SR to 0x70000000 and VBR to 0, and it leaves both shadow registers unchanged.
- R5: The redirect target is VBR+0x400 for an exception with `exc_tlb`=1, VBR+0x100 for an exception with `exc_tlb`=0, and VBR+0x600 for an interrupt. The sum wraps modulo 2^32.
- R6: `vbr_we` loads `vbr_wdata` into VBR, and VBR holds its value while it is not written and no reset request arrives.
- R7: While SR bit 28 is 1, exception and interrupt requests are ignored: they cause no redirect and no register change.
- R8: One action is taken per cycle, in the priority order reset, exception, return, interrupt.
- R9: `redir_vld` is high for exactly the one cycle after the edge that takes a request. It is low after any cycle with no taken request.
- R10: A taken return redirects to the saved PC and loads SR from the saved SR.
- R11: `sr_we` loads `sr_wdata` into SR only in a cycle in which no request is taken.
- R12: While `rst_n` is low, SR reads 0x70000000 and all other registers and `redir_vld` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset request |
| exc_req | input | 1 | Synchronous exception request |
| exc_tlb | input | 1 | Exception is a TLB miss |
| exc_code | input | 12 | Exception event code |
| irq_req | input | 1 | Interrupt request |
| irq_code | input | 12 | Interrupt event code |
| rte_req | input | 1 | Return from exception |
| pc_in | input | 32 | PC of the interrupted instruction |
| sr_we | input | 1 | Software SR write |
| sr_wdata | input | 32 | SR write data |
| vbr_we | input | 1 | Software VBR write |
| vbr_wdata | input | 32 | VBR write data |
| redir_vld | output | 1 | One-cycle redirect pulse to fetch |
| redir_pc | output | 32 | Redirect target |
| sr_q | output | 32 | Status register |
| spc_q | output | 32 | Saved PC |
| ssr_q | output | 32 | Saved SR |
| vbr_q | output | 32 | Vector base register |
| exc_evt | output | 12 | Exception event code register |
| irq_evt | output | 12 | Interrupt event code register |

## Verification
Every result of a taken request is registered at the edge that samples the request, so all outputs are due one cycle after the stimulus. The bench drives inputs at the falling edge and compares the outputs at the next falling edge, which falls half a cycle after the capturing rising edge. It then drops all requests for one cycle and checks that the redirect pulse has fallen, since that check is due one cycle after the inputs go idle. A sweep covers all 64 combinations of the four request lines, the block bit and the TLB flag, against a register model held in the bench.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 12,
  parameter int unsigned BL_BIT = 28,
  parameter int unsigned RB_BIT = 29,
  parameter int unsigned MD_BIT = 30,
  parameter logic [AW-1:0] RST_VEC = 32'hA000_0000,
  parameter logic [AW-1:0] OFS_GEN = 32'h0000_0100,
  parameter logic [AW-1:0] OFS_TLB = 32'h0000_0400,
  parameter logic [AW-1:0] OFS_IRQ = 32'h0000_0600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_req,
  input  logic          exc_req,
  input  logic          exc_tlb,
  input  logic [CW-1:0] exc_code,
  input  logic          irq_req,
  input  logic [CW-1:0] irq_code,
  input  logic          rte_req,
  input  logic [AW-1:0] pc_in,
  input  logic          sr_we,
  input  logic [AW-1:0] sr_wdata,
  input  logic          vbr_we,
  input  logic [AW-1:0] vbr_wdata,
  output logic          redir_vld,
  output logic [AW-1:0] redir_pc,
  output logic [AW-1:0] sr_q,
  output logic [AW-1:0] spc_q,
  output logic [AW-1:0] ssr_q,
  output logic [AW-1:0] vbr_q,
  output logic [CW-1:0] exc_evt,
  output logic [CW-1:0] irq_evt
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] MODE_MASK = (ONE << BL_BIT) | (ONE << RB_BIT) | (ONE << MD_BIT);

  logic blk;
  logic take_exc, take_rte, take_irq, take_ent;
  logic [AW-1:0] target;

  assign blk      = sr_q[BL_BIT];
  assign take_exc = !rst_req && exc_req && !blk;
  assign take_rte = !rst_req && !take_exc && rte_req;
  assign take_irq = !rst_req && !take_exc && !rte_req && irq_req && !blk;
  assign take_ent = take_exc || take_irq;

  always_comb begin
    if (rst_req)       target = RST_VEC;
    else if (take_exc) target = vbr_q + (exc_tlb ? OFS_TLB : OFS_GEN);
    else if (take_rte) target = spc_q;
    else               target = vbr_q + OFS_IRQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= MODE_MASK;
      spc_q     <= '0;
      ssr_q     <= '0;
      vbr_q     <= '0;
      exc_evt   <= '0;
      irq_evt   <= '0;
      redir_vld <= 1'b0;
      redir_pc  <= '0;
    end else begin
      redir_vld <= rst_req || take_ent || take_rte;
      redir_pc  <= target;

      if (rst_req)       vbr_q <= '0;
      else if (vbr_we)   vbr_q <= vbr_wdata;

      if (rst_req)       sr_q <= MODE_MASK;
      else if (take_ent) sr_q <= sr_q | MODE_MASK;
      else if (take_rte) sr_q <= ssr_q;
      else if (sr_we)    sr_q <= sr_wdata;

      if (take_ent) begin
        spc_q <= pc_in;
        ssr_q <= sr_q;
      end

      if (rst_req)       exc_evt <= '0;
      else if (take_exc) exc_evt <= exc_code;

      if (take_irq)      irq_evt <= irq_code;
    end
  end

  a_r1_ctx_save: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_ent) |-> (spc_q == $past(pc_in)) && (ssr_q == $past(sr_q)));

  a_r2_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_ent) |-> ((sr_q & MODE_MASK) == MODE_MASK) &&
                        ((sr_q & ~MODE_MASK) == ($past(sr_q) & ~MODE_MASK)));

  a_r4_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_req) |-> redir_vld && (redir_pc == RST_VEC) && (vbr_q == '0));

  a_r7_bl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sr_q[BL_BIT] && !rst_req && !rte_req) |-> !redir_vld);

  a_r10_rte: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rte_req && !rst_req && !(exc_req && !sr_q[BL_BIT])) |->
      redir_vld && (sr_q == $past(ssr_q)) && (redir_pc == $past(spc_q)));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_req && !exc_req && !irq_req && !rte_req) |-> !redir_vld);

endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 0, exc_req = 0, exc_tlb = 0, irq_req = 0, rte_req = 0;
  logic [11:0] exc_code = 0, irq_code = 0;
  logic [31:0] pc_in = 0, sr_wdata = 0, vbr_wdata = 0;
  logic sr_we = 0, vbr_we = 0;
  logic redir_vld;
  logic [31:0] redir_pc, sr_q, spc_q, ssr_q, vbr_q;
  logic [11:0] exc_evt, irq_evt;

  int total = 0;
  int bad = 0;

  logic [31:0] m_sr, m_spc, m_ssr, m_vbr, e_pc;
  logic [11:0] m_ee, m_ie;
  logic e_vld;

  always #4 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .exc_req(exc_req), .exc_tlb(exc_tlb),
    .exc_code(exc_code), .irq_req(irq_req), .irq_code(irq_code), .rte_req(rte_req),
    .pc_in(pc_in), .sr_we(sr_we), .sr_wdata(sr_wdata), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .sr_q(sr_q), .spc_q(spc_q), .ssr_q(ssr_q),
    .vbr_q(vbr_q), .exc_evt(exc_evt), .irq_evt(irq_evt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs;
    rst_req = 0; exc_req = 0; exc_tlb = 0; irq_req = 0; rte_req = 0;
    sr_we = 0; vbr_we = 0;
  endtask

  task automatic check_state(input string tag);
    check({tag, " sr"}, sr_q, m_sr);
    check({tag, " spc"}, spc_q, m_spc);
    check({tag, " ssr"}, ssr_q, m_ssr);
    check({tag, " vbr"}, vbr_q, m_vbr);
    check({tag, " exc_evt"}, {20'd0, exc_evt}, {20'd0, m_ee});
    check({tag, " irq_evt"}, {20'd0, irq_evt}, {20'd0, m_ie});
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_sr = 32'h7000_0000; m_spc = 0; m_ssr = 0; m_vbr = 0; m_ee = 0; m_ie = 0;
    @(negedge clk);
    @(negedge clk);
    check("R12 redir_vld in reset", {31'd0, redir_vld}, 32'd0);
    check_state("R12 reset");
    rst_n = 1'b1;
    tick;
    check("R9 idle after reset", {31'd0, redir_vld}, 32'd0);

    for (int i = 0; i < 64; i++) begin
      logic r, x, t, q, b, tl;
      r = i[0]; x = i[1]; t = i[2]; q = i[3]; b = i[4]; tl = i[5];

      sr_we = 1; sr_wdata = ((32'h0000_00F0 ^ (i * 32'h0101_0003)) & ~32'h7000_0000) | ({31'd0, b} << 28);
      vbr_we = 1; vbr_wdata = 32'h8000_0000 + i * 32'h0000_1000;
      tick;
      m_sr = sr_wdata; m_vbr = vbr_wdata;
      idle_inputs;
      check_state("R6 R11 setup");
      check("R9 no redirect on writes", {31'd0, redir_vld}, 32'd0);

      rst_req = r; exc_req = x; rte_req = t; irq_req = q; exc_tlb = tl;
      pc_in = 32'h0C00_0000 + i * 4;
      exc_code = 12'h040 + i[11:0]; irq_code = 12'h400 + i[11:0];
      e_vld = 1'b0; e_pc = 0;
      if (r) begin
        e_vld = 1; e_pc = 32'hA000_0000; m_sr = 32'h7000_0000; m_vbr = 0; m_ee = 0;
      end else if (x && !b) begin
        e_vld = 1; e_pc = m_vbr + (tl ? 32'h400 : 32'h100);
        m_spc = pc_in; m_ssr = m_sr; m_sr = m_sr | 32'h7000_0000; m_ee = exc_code;
      end else if (t) begin
        e_vld = 1; e_pc = m_spc; m_sr = m_ssr;
      end else if (q && !b) begin
        e_vld = 1; e_pc = m_vbr + 32'h600;
        m_spc = pc_in; m_ssr = m_sr; m_sr = m_sr | 32'h7000_0000; m_ie = irq_code;
      end
      tick;
      idle_inputs;
      check($sformatf("R8 R7 redir_vld combo %0d", i), {31'd0, redir_vld}, {31'd0, e_vld});
      if (e_vld) check($sformatf("R4 R5 R10 redir_pc combo %0d", i), redir_pc, e_pc);
      check_state($sformatf("R1 R2 R3 R4 R7 R10 combo %0d", i));
      tick;
      check($sformatf("R9 pulse ends combo %0d", i), {31'd0, redir_vld}, 32'd0);
      check_state("R6 hold");
    end

    sr_we = 1; sr_wdata = 32'h0000_0001; vbr_we = 1; vbr_wdata = 32'hFFFF_FF80;
    tick;
    idle_inputs;
    exc_req = 1; exc_tlb = 0; pc_in = 32'h1234_5678; exc_code = 12'hABC;
    tick;
    idle_inputs;
    check("R5 wrap target", redir_pc, 32'h0000_0080);
    check("R2 sr after wrap entry", sr_q, 32'h7000_0001);
    check("R1 spc wrap entry", spc_q, 32'h1234_5678);
    check("R3 exc_evt wrap entry", {20'd0, exc_evt}, 32'h0000_0ABC);

    rst_req = 1; vbr_we = 1; vbr_wdata = 32'h5555_0000;
    tick;
    idle_inputs;
    check("R4 reset beats vbr write", vbr_q, 32'd0);
    check("R4 reset keeps spc", spc_q, 32'h1234_5678);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule